// File: doc/BRIEF.md
# Input-Change Interrupt Controller

This block watches a vector of already-filtered digital input levels, grouped into nibbles, and raises a sticky per-stage flag whenever the filtered level of a stage changes. A stage can raise a flag only when two conditions hold: its nibble is configured for input, and its bit in an 8-bit enable register is set. While any flag is set, an active-low interrupt line is driven low. The flag vector is presented as a plain output so that the surrounding bus logic can return it on a read.

Software has two ways to service the interrupt. A one-cycle end-of-interrupt strobe clears every flag at once. Any change that coincides with that strobe is dropped. The alternative is to clear flags one stage at a time: write the enable register with the stage's bit at zero, which wipes that flag, then write the bit back to one, which arms the stage again. The change detector compares each level with its value from the previous clock. Both polarities of change therefore count.

Top module: `icirq_top`

## Requirements
- R1: One cycle after a cycle with `rst` high, `flags_o` is all zero, `irq_n_o` is 1 and every enable bit is 0. After reset, no flag can be set until the enable register is written.
- R2: A low-to-high change on `lvl_i[i]` sets `flags_o[i]` at the first clock edge that samples the new level, provided that bit `i` of the enable register is 1, the stage's nibble is in input mode and `eoi_i` is low.
- R3: A high-to-low change on `lvl_i[i]` sets the flag under the same conditions and with the same timing as R2.
- R4: `out_mode_i[g]` = 1 puts stages 4g to 4g+3 in output mode. Level changes on those stages never set their flags, while stages in the other nibble keep working.
- R5: A stage whose enable bit is 0 never sets its flag, whatever its level does.
- R6: `irq_n_o` is 0 exactly in the cycles in which `flags_o` is not all zero, and it changes in the same cycle as the flags.
- R7: A cycle with `eoi_i` high clears all flags at that clock edge and returns `irq_n_o` to 1.
- R8: A level change sampled in the same cycle as `eoi_i` is lost. It leaves no flag, either then or in later cycles.
- R9: Writing the enable register with bit `i` at 0 clears `flags_o[i]` one cycle after the write takes effect, and leaves the other flags untouched. Writing bit `i` back to 1 lets later changes set the flag again.
- R10: A flag stays set after its stage's level changes again or returns to its old value. Only R7 or R9 clear it.
- R11: A write to the enable register (`en_wr_i` high, data on `en_wdata_i`) takes effect at the clock edge that samples it. A change sampled at that same edge is judged by the old enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_i | input | 8 | Filtered input levels, one per stage |
| out_mode_i | input | 2 | Per-nibble mode, 1 = output (bit g covers stages 4g..4g+3) |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data, 1 = stage may raise a flag |
| eoi_i | input | 1 | End-of-interrupt strobe, clears all flags |
| flags_o | output | 8 | Sticky change flags for readback |
| irq_n_o | output | 1 | Active-low interrupt, low while any flag is set |

## Verification
The hardest cases to reach are collisions in time: a level change in the very cycle of the end-of-interrupt strobe, and a change in the very cycle an enable write lands. Each needs two stimuli on the same clock edge. The bench therefore drives the level edge and the strobe or write together on one falling edge, then samples the flags both one cycle and two cycles later to show that nothing was stored and nothing is set late. Per-stage clearing is reached by first setting two flags, then dropping one enable bit and toggling that stage while it is disabled, and finally re-enabling it and changing its level again.

// File: rtl/icirq_pkg.sv
package icirq_pkg;
  parameter int GROUP_W_DEF = 4;
  parameter int GROUPS_DEF  = 2;

  function automatic int stage_group(input int stage, input int group_w);
    return stage / group_w;
  endfunction
endpackage

// File: rtl/icirq_change_det.sv
module icirq_change_det #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] prev_q;

  // Previous-cycle copy; loaded during reset too so no false edge follows it.
  always_ff @(posedge clk) begin
    prev_q <= lvl_i;
  end

  assign chg_o = lvl_i ^ prev_q;
endmodule

// File: rtl/icirq_enable_reg.sv
module icirq_enable_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (rst)       en_o <= '0;
    else if (wr_i) en_o <= wdata_i;
  end

  p_en_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(en_o));
  p_en_reset_r1: assert property (@(posedge clk)
    rst |=> (en_o == '0));
endmodule

// File: rtl/icirq_flag_cell.sv
module icirq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic in_mode_i,
  input  logic chg_i,
  input  logic eoi_i,
  output logic flag_o,
  output logic flag_next_o
);
  always_comb begin
    if (!en_i)      flag_next_o = 1'b0;
    else if (eoi_i) flag_next_o = 1'b0;
    else            flag_next_o = flag_o | (chg_i & in_mode_i);
  end

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= flag_next_o;
  end

  p_set_on_change_r2: assert property (@(posedge clk) disable iff (rst)
    (en_i && in_mode_i && chg_i && !eoi_i) |=> flag_o);
  p_no_set_output_r4: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && !in_mode_i) |=> !flag_o);
  p_disabled_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !flag_o);
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_o && en_i && !eoi_i) |=> flag_o);
endmodule

// File: rtl/icirq_top.sv
module icirq_top #(
  parameter int GROUP_W = icirq_pkg::GROUP_W_DEF,
  parameter int GROUPS  = icirq_pkg::GROUPS_DEF,
  localparam int N      = GROUP_W * GROUPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      lvl_i,
  input  logic [GROUPS-1:0] out_mode_i,
  input  logic              en_wr_i,
  input  logic [N-1:0]      en_wdata_i,
  input  logic              eoi_i,
  output logic [N-1:0]      flags_o,
  output logic              irq_n_o
);
  logic [N-1:0] chg;
  logic [N-1:0] en_q;
  logic [N-1:0] in_mode;
  logic [N-1:0] flag_next;

  icirq_change_det #(.N(N)) u_det (
    .clk   (clk),
    .lvl_i (lvl_i),
    .chg_o (chg)
  );

  icirq_enable_reg #(.N(N)) u_en (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (en_wr_i),
    .wdata_i (en_wdata_i),
    .en_o    (en_q)
  );

  for (genvar i = 0; i < N; i++) begin : g_stage
    assign in_mode[i] = ~out_mode_i[icirq_pkg::stage_group(i, GROUP_W)];

    icirq_flag_cell u_cell (
      .clk         (clk),
      .rst         (rst),
      .en_i        (en_q[i]),
      .in_mode_i   (in_mode[i]),
      .chg_i       (chg[i]),
      .eoi_i       (eoi_i),
      .flag_o      (flags_o[i]),
      .flag_next_o (flag_next[i])
    );
  end

  // Registered from the next-state flags so the pin moves with the flags.
  always_ff @(posedge clk) begin
    if (rst) irq_n_o <= 1'b1;
    else     irq_n_o <= ~(|flag_next);
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (flags_o == '0 && irq_n_o));
  p_irq_tracks_r6: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == (flags_o == '0));
  p_eoi_clears_r7: assert property (@(posedge clk) disable iff (rst)
    eoi_i |=> (flags_o == '0 && irq_n_o));
endmodule

// File: tb/icirq_top_test.sv
module icirq_top_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] lvl_i = '0;
  logic [1:0]   out_mode_i = '0;
  logic         en_wr_i = 1'b0;
  logic [N-1:0] en_wdata_i = '0;
  logic         eoi_i = 1'b0;
  logic [N-1:0] flags_o;
  logic         irq_n_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  icirq_top uut (
    .clk        (clk),
    .rst        (rst),
    .lvl_i      (lvl_i),
    .out_mode_i (out_mode_i),
    .en_wr_i    (en_wr_i),
    .en_wdata_i (en_wdata_i),
    .eoi_i      (eoi_i),
    .flags_o    (flags_o),
    .irq_n_o    (irq_n_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] exp_f);
    logic exp_n;
    exp_n = (exp_f == '0);
    checks++;
    if (flags_o !== exp_f || irq_n_o !== exp_n) begin
      fails++;
      $display("FAIL %s: flags=%h irq_n=%b expected flags=%h irq_n=%b",
               req, flags_o, irq_n_o, exp_f, exp_n);
    end
  endtask

  task automatic write_en(input logic [N-1:0] v);
    en_wr_i = 1'b1; en_wdata_i = v;
    step();
    en_wr_i = 1'b0;
  endtask

  task automatic clear_all();
    eoi_i = 1'b1;
    step();
    eoi_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    rst = 1'b0;
    chk("R1 reset state", 8'h00);
    lvl_i[6] = 1'b1; step();
    chk("R1 enables zero after reset", 8'h00);
    lvl_i[6] = 1'b0; step();
    chk("R5 disabled stage ignored", 8'h00);
  endtask

  task automatic t_rise_fall();
    write_en(8'hFF);
    lvl_i[2] = 1'b1; step();
    chk("R2 rising change flagged, R6 irq low", 8'h04);
    clear_all();
    chk("R7 eoi clears", 8'h00);
    lvl_i[2] = 1'b0; step();
    chk("R3 falling change flagged", 8'h04);
    clear_all();
    chk("R7 eoi clears again", 8'h00);
  endtask

  task automatic t_sticky();
    lvl_i[5] = 1'b1; step();
    lvl_i[5] = 1'b0; step();
    step();
    chk("R10 flag sticky after level returns", 8'h20);
    clear_all();
  endtask

  task automatic t_mode();
    out_mode_i = 2'b10;
    lvl_i[6] = 1'b1; lvl_i[1] = 1'b1; step();
    chk("R4 output nibble ignored", 8'h02);
    lvl_i[6] = 1'b0; lvl_i[1] = 1'b0; step();
    chk("R4 output nibble ignored on fall", 8'h02);
    clear_all();
    out_mode_i = 2'b00;
    step();
    chk("R4 mode return leaves no flag", 8'h00);
  endtask

  task automatic t_eoi_race();
    lvl_i[3] = 1'b1; eoi_i = 1'b1; step();
    eoi_i = 1'b0;
    chk("R8 change during eoi lost", 8'h00);
    step();
    chk("R8 no late flag", 8'h00);
  endtask

  task automatic t_en_clear();
    lvl_i[0] = 1'b1; lvl_i[7] = 1'b1; step();
    chk("R2 two stages flagged", 8'h81);
    write_en(8'hFE); step();
    chk("R9 single flag cleared", 8'h80);
    lvl_i[0] = 1'b0; step();
    chk("R5 disabled stage ignored", 8'h80);
    write_en(8'hFF);
    lvl_i[0] = 1'b1; step();
    chk("R9 stage rearmed", 8'h81);
    clear_all();
  endtask

  task automatic t_en_timing();
    write_en(8'h00);
    en_wr_i = 1'b1; en_wdata_i = 8'hFF; lvl_i[4] = 1'b1; step();
    en_wr_i = 1'b0;
    chk("R11 old enable applies at write edge", 8'h00);
    step();
    chk("R11 no late flag", 8'h00);
    lvl_i[4] = 1'b0; step();
    chk("R11 new enable active", 8'h10);
    clear_all();
    chk("R7 final clear", 8'h00);
  endtask

  initial begin
    step();
    t_reset();
    t_rise_fall();
    t_sticky();
    t_mode();
    t_eoi_race();
    t_en_clear();
    t_en_timing();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule